// File: doc/BRIEF.md
# Dual-Channel Output Formatter and Multiplexer

This block takes two 10-bit conversion codes, I and Q, that are sampled together once per sample period, and drives them onto two 10-bit output buses. It runs on a clock at twice the sample rate. An internal slot phase alternates every fast cycle between a capture slot, where the codes are taken in, and an I slot. Every half-period of the sample clock therefore maps to one synchronous fast cycle. The codes pass through a short pipeline and a coding stage that emits either offset binary or two's complement.

A bus-select control picks between two modes. In parallel mode each channel has its own bus and both buses update together. In multiplexed mode I and Q take turns on the I bus and the Q bus is held at zero. A strobe marks which channel is on the bus. A hold request freezes the pipeline, the slot phase and all outputs so that the last result stays on the pins. The format and bus-select controls pass through two-flop synchronizers before use, and a change to either may corrupt a word or two while it settles.

Top module: `iq_out_formatter`

## Requirements
- R1: In parallel mode (par_mode_i = 1), the code captured at a capture edge E appears on i_bus_o and q_bus_o after fast edge E+5 (an I-slot edge), and neither bus changes at capture-slot edges.
- R2: In multiplexed mode (par_mode_i = 0), q_bus_o is held at all zeros.
- R3: In multiplexed mode, the I code captured at edge E is on i_bus_o after edge E+5 and the Q code of the same capture is on i_bus_o after edge E+6.
- R4: iq_strobe_o is driven to 1 at every I-slot edge and to 0 at every capture-slot edge, so it is high while I data is on i_bus_o and rises each time new data is presented.
- R5: With fmt_twos_i = 0 the output code equals the input code (offset binary, mid-scale 10'h200). With fmt_twos_i = 1 the MSB is inverted (mid-scale 10'h000, positive full scale 10'h1FF, negative full scale 10'h200).
- R6: Input codes are taken only at capture edges, which are the first fast edge after reset release and every second edge after it. Values present at the other edges have no effect on the outputs.
- R7: While hold_i is 1, i_bus_o, q_bus_o and iq_strobe_o keep their values. After release the stream resumes with no lost or repeated sample, as though the held edges had never occurred.
- R8: During reset both buses and the strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock at twice the sample rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| i_code_i | input | 10 | Raw I conversion code, offset binary |
| q_code_i | input | 10 | Raw Q conversion code, offset binary |
| fmt_twos_i | input | 1 | 1 selects two's complement, 0 offset binary |
| par_mode_i | input | 1 | 1 selects parallel mode, 0 multiplexed mode |
| hold_i | input | 1 | Standby/power-down hold, freezes the block |
| i_bus_o | output | 10 | I bus, which carries both channels in multiplexed mode |
| q_bus_o | output | 10 | Q bus, zero in multiplexed mode |
| iq_strobe_o | output | 1 | Channel strobe, high during the I slot |

## Verification
Counting fast edges from reset release, a code captured at edge E is due on the buses after edge E+5. In multiplexed mode the Q word of that capture follows after E+6. In parallel mode the buses hold their values through E+6. The bench keeps its own edge count, drives a new input before each edge, and samples on the falling clock, where it derives the capture edge from the parity of the count and the offsets above. All 1024 codes pass on both channels in every mode and format, with junk driven on non-capture edges. During a hold the count is frozen, so the offsets stay valid after release.

// File: rtl/iq_out_pkg.sv
package iq_out_pkg;
  localparam int CODE_W_DEF = 10;
  localparam int PRE_STAGES_DEF = 2;
  localparam int SYNC_DEPTH = 2;
  localparam logic SLOT_CAP = 1'b0;
  localparam logic SLOT_I = 1'b1;
endpackage

// File: rtl/iq_sync.sv
module iq_sync #(
  parameter int W = 2,
  parameter int DEPTH = iq_out_pkg::SYNC_DEPTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_flop
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[DEPTH-1];
endmodule

// File: rtl/iq_pipe.sv
module iq_pipe #(
  parameter int W = 20,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= '0;
      else if (en_i) stg[g] <= (g == 0) ? d_i : stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/iq_fmt.sv
module iq_fmt #(
  parameter int W = 10
) (
  input  logic         twos_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] code_o
);
  // offset binary -> two's complement by flipping the sign bit
  assign code_o = {code_i[W-1] ^ twos_i, code_i[W-2:0]};
endmodule

// File: rtl/iq_out_formatter.sv
module iq_out_formatter #(
  parameter int CODE_W = iq_out_pkg::CODE_W_DEF,
  parameter int PRE_STAGES = iq_out_pkg::PRE_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] i_code_i,
  input  logic [CODE_W-1:0] q_code_i,
  input  logic              fmt_twos_i,
  input  logic              par_mode_i,
  input  logic              hold_i,
  output logic [CODE_W-1:0] i_bus_o,
  output logic [CODE_W-1:0] q_bus_o,
  output logic              iq_strobe_o
);
  import iq_out_pkg::*;

  localparam int PAIR_W = 2 * CODE_W;
  localparam int NCH = 2;

  logic              slot_i_q;
  logic              adv;
  logic              fmt_s;
  logic              par_s;
  logic [PAIR_W-1:0] pipe_w;
  logic [CODE_W-1:0] raw_w [NCH];
  logic [CODE_W-1:0] cod_w [NCH];
  logic [CODE_W-1:0] out_q [NCH];

  assign adv = ~hold_i;

  iq_sync #(.W(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fmt_twos_i, par_mode_i}),
    .q_o   ({fmt_s, par_s})
  );

  iq_pipe #(.W(PAIR_W), .DEPTH(PRE_STAGES)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (adv && (slot_i_q == SLOT_CAP)),
    .d_i   ({i_code_i, q_code_i}),
    .q_o   (pipe_w)
  );

  assign raw_w[0] = pipe_w[PAIR_W-1:CODE_W];
  assign raw_w[1] = pipe_w[CODE_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iq_fmt #(.W(CODE_W)) u_fmt (
      .twos_i(fmt_s),
      .code_i(raw_w[c]),
      .code_o(cod_w[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q[c] <= '0;
      else if (adv && (slot_i_q == SLOT_CAP)) out_q[c] <= cod_w[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_i_q    <= SLOT_CAP;
      i_bus_o     <= '0;
      q_bus_o     <= '0;
      iq_strobe_o <= 1'b0;
    end else if (adv) begin
      slot_i_q <= ~slot_i_q;
      if (slot_i_q == SLOT_I) begin
        i_bus_o     <= out_q[0];
        q_bus_o     <= par_s ? out_q[1] : '0;
        iq_strobe_o <= 1'b1;
      end else begin
        iq_strobe_o <= 1'b0;
        // multiplexed: Q takes the second half-slot of the I bus
        if (!par_s) begin
          i_bus_o <= out_q[1];
          q_bus_o <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/iq_out_formatter_chk.sv
module iq_out_formatter_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_i,
  input logic              par_s,
  input logic              slot_i_q,
  input logic [CODE_W-1:0] i_bus_o,
  input logic [CODE_W-1:0] q_bus_o,
  input logic              iq_strobe_o
);
  // R7
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(i_bus_o) && $stable(q_bus_o) && $stable(iq_strobe_o)));

  // R4
  strobe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && slot_i_q) |=> iq_strobe_o);

  // R4
  strobe_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !slot_i_q) |=> !iq_strobe_o);

  // R2
  mux_qzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !par_s && slot_i_q) |=> (q_bus_o == '0));

  // R1
  par_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && par_s && !slot_i_q) |=> ($stable(i_bus_o) && $stable(q_bus_o)));
endmodule

bind iq_out_formatter iq_out_formatter_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_i     (hold_i),
  .par_s      (par_s),
  .slot_i_q   (slot_i_q),
  .i_bus_o    (i_bus_o),
  .q_bus_o    (q_bus_o),
  .iq_strobe_o(iq_strobe_o)
);

// File: tb/iq_out_formatter_bench.sv
module iq_out_formatter_bench;
  localparam int W = 10;
  localparam int NEDGES = 2100;
  localparam int HOLD_AT = 600;
  localparam int HOLD_LEN = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] i_code = '0;
  logic [W-1:0] q_code = '0;
  logic         fmt_twos = 1'b0;
  logic         par_mode = 1'b0;
  logic         hold = 1'b0;
  logic [W-1:0] i_bus;
  logic [W-1:0] q_bus;
  logic         strobe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  iq_out_formatter u_iq_out_formatter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .i_code_i   (i_code),
    .q_code_i   (q_code),
    .fmt_twos_i (fmt_twos),
    .par_mode_i (par_mode),
    .hold_i     (hold),
    .i_bus_o    (i_bus),
    .q_bus_o    (q_bus),
    .iq_strobe_o(strobe)
  );

  // even edges are capture edges and get swept codes; odd edges get junk (R6)
  function automatic logic [W-1:0] fval(int m);
    if (m % 2 == 0) return W'((m / 2) % 1024);
    return W'((m * 7 + 3) % 1024);
  endfunction

  function automatic logic [W-1:0] gval(int m);
    if (m % 2 == 0) return W'(1023 - ((m / 2) % 1024));
    return W'((m * 13) % 1024);
  endfunction

  function automatic logic [W-1:0] conv(logic [W-1:0] x, logic twos);
    return twos ? (x ^ W'(512)) : x;
  endfunction

  task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_edge(int m, logic fmt, logic par);
    int e;
    string ti;
    ti = fmt ? "R5 R6" : "R6";
    if (m % 2 == 1) begin
      e = m - 5;
      cmp($sformatf("%s %s I slot i_bus m=%0d", par ? "R1" : "R3", ti, m), i_bus, conv(fval(e), fmt));
      if (par) cmp($sformatf("R1 %s q_bus m=%0d", ti, m), q_bus, conv(gval(e), fmt));
      else cmp($sformatf("R2 q_bus m=%0d", m), q_bus, '0);
      cmp($sformatf("R4 strobe m=%0d", m), W'(strobe), W'(1));
    end else begin
      e = m - 6;
      if (par) begin
        cmp($sformatf("R1 %s hold i_bus m=%0d", ti, m), i_bus, conv(fval(e), fmt));
        cmp($sformatf("R1 %s hold q_bus m=%0d", ti, m), q_bus, conv(gval(e), fmt));
      end else begin
        cmp($sformatf("R3 %s Q slot i_bus m=%0d", ti, m), i_bus, conv(gval(e), fmt));
        cmp($sformatf("R2 q_bus m=%0d", m), q_bus, '0);
      end
      cmp($sformatf("R4 strobe m=%0d", m), W'(strobe), W'(0));
    end
  endtask

  task automatic run(logic fmt, logic par);
    logic [W-1:0] si, sq;
    logic ss;
    rst_n = 1'b0;
    hold = 1'b0;
    fmt_twos = fmt;
    par_mode = par;
    i_code = '1;
    q_code = '1;
    repeat (3) @(negedge clk);
    cmp("R8 reset i_bus", i_bus, '0);
    cmp("R8 reset q_bus", q_bus, '0);
    cmp("R8 reset strobe", W'(strobe), '0);
    rst_n = 1'b1;
    for (int m = 0; m < NEDGES; m++) begin
      if (m == HOLD_AT) begin
        si = i_bus;
        sq = q_bus;
        ss = strobe;
        hold = 1'b1;
        for (int h = 0; h < HOLD_LEN; h++) begin
          i_code = W'(h * 101 + 7);
          q_code = W'(h * 57 + 3);
          @(posedge clk);
          @(negedge clk);
          cmp($sformatf("R7 held i_bus h=%0d", h), i_bus, si);
          cmp($sformatf("R7 held q_bus h=%0d", h), q_bus, sq);
          cmp($sformatf("R7 held strobe h=%0d", h), W'(strobe), W'(ss));
        end
        hold = 1'b0;
      end
      i_code = fval(m);
      q_code = gval(m);
      @(posedge clk);
      @(negedge clk);
      if (m >= 6) check_edge(m, fmt, par);
    end
  endtask

  initial begin
    run(1'b0, 1'b1);
    run(1'b1, 1'b1);
    run(1'b0, 1'b0);
    run(1'b1, 1'b0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule